// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from a bank of programmable compare values. A horizontal counter steps once per enabled pixel cycle and wraps at the programmed period. A vertical counter steps once per horizontal wrap. Each horizontal period is one half-line, so two consecutive vertical counts make one output line. The even count is the first half and the odd count is the second half. Counting half-lines lets the display window start in either half of a line, and it lets an interlaced field sit half a line away from the other field.

From the two counters and the compare values the block derives the horizontal and vertical sync pulses, each with its own polarity. It also derives a display-enable strobe, a border-enable strobe and an output line index. The line index follows the scan mode: progressive, interlaced or double-scanned. A mode bit lengthens the vertical period by a fixed number of half-lines, which selects the slower of two frame rates. The pixel-clock enable input stands in for an external clock divider. The counters advance only in cycles where that enable is high.

Top module: `rasterTimingGen`

## Requirements
- R1: During and straight after reset both counters and the line index are 0, hSync and vSync are 1 (inactive, active-low polarity), and dispEn and bordEn are 0. After reset the horizontal and vertical period and sync-start values are all ones, and every other compare value, the half-select bit and the mode bits are 0.
- R2: At each clock edge with pixEn high, hCount increments by one, or becomes 0 if it is greater than or equal to the horizontal period (address 0). With pixEn low, hCount and vCount hold.
- R3: At each horizontal wrap, vCount increments by one, or becomes 0 if it is greater than or equal to the vertical period. The vertical period is the value at address 8, plus PAL_EXTRA when mode bit 4 is set.
- R4: hSync is active while hCount >= the horizontal sync start (address 5) and vCount is odd. Mode bit 0 sets the polarity: 0 gives an active-low output and 1 gives an active-high output.
- R5: vSync is active while vCount >= the vertical sync start (address 13). Mode bit 1 sets the polarity: 0 gives an active-low output and 1 gives an active-high output.
- R6: dispEn is 1 exactly when all three of these hold: display begin (address 3, bits 8:0) <= hCount < display end (address 4); vertical display begin (address 11) <= vCount < vertical display end (address 12); vCount bit 0 equals the half-select bit (bit 9 of the address 3 write).
- R7: bordEn is 1 exactly when dispEn is 0 and both of these hold: border begin (address 1) <= hCount < border end (address 2); vertical border begin (address 9) <= vCount < vertical border end (address 10).
- R8: lineIdx is vCount>>1 by default. With mode bit 2 (interlace) it is {vCount[10:1], field}. The field bit is 0 after reset and toggles at every vertical wrap. Mode bit 3 (double scan) gives vCount>>2 and takes precedence over interlace.
- R9: A write on the configuration port changes its register from the following cycle. The mode register is at address 15. Writes to addresses 6, 7 and 14 change nothing. A lowered period takes effect at once, even while the counter already exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixEn | input | 1 | Pixel-clock enable; counters step only when high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 11 | Configuration write data |
| hSync | output | 1 | Horizontal sync, polarity per mode bit 0 |
| vSync | output | 1 | Vertical sync, polarity per mode bit 1 |
| dispEn | output | 1 | Active display strobe |
| bordEn | output | 1 | Border area strobe |
| hCount | output | 9 | Horizontal (pixel) counter |
| vCount | output | 11 | Vertical half-line counter |
| lineIdx | output | 11 | Output line index per scan mode |

## Verification
The bench programs a small raster of 10 cycles per half-line and 12 half-lines per frame. It then sweeps all 32 mode-register values. The sweep tells the sync polarities apart, shows double scan taking precedence over interlace, and shows the field toggling only when interlace is visible in lineIdx. It also shows the frame-rate bit lengthening the period by exactly PAL_EXTRA. Every odd mode value flips the half-select bit, so display appearing on even or on odd half-lines shows the half select at work. Those runs also gap pixEn, which separates counter holding from counter stepping. Further sequences write unmapped addresses and lower the horizontal period below the current count, to check that stray writes change nothing and that the wrap uses a greater-or-equal compare.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Compare register slots, shared by the horizontal and vertical banks
  localparam int IDX_TOT  = 0;
  localparam int IDX_BBEG = 1;
  localparam int IDX_BEND = 2;
  localparam int IDX_DBEG = 3;
  localparam int IDX_DEND = 4;
  localparam int IDX_SYNC = 5;
  localparam int N_CMP    = 6;

  // Vertical bank starts at this address; mode register sits at the top
  localparam int V_BASE   = 8;

  // Mode register bit positions
  localparam int MB_HPOL  = 0;
  localparam int MB_VPOL  = 1;
  localparam int MB_ILACE = 2;
  localparam int MB_DBL   = 3;
  localparam int MB_F50   = 4;
  localparam int MODE_W   = 5;

  // Strobes and mode flags passed from control to datapath
  typedef struct packed {
    logic hWrap;
    logic vWrap;
    logic hSyncIn;
    logic vSyncIn;
    logic hDispIn;
    logic vDispIn;
    logic hBordIn;
    logic vBordIn;
    logic dispHalf;
    logic hPol;
    logic vPol;
    logic ilace;
    logic dblScan;
  } rasterStb_t;

endpackage

// File: rtl/rasterCtrl.sv
module rasterCtrl
  import raster_pkg::*;
#(
  parameter int H_W       = 9,
  parameter int V_W       = 11,
  parameter int A_W       = 4,
  parameter int PAL_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [A_W-1:0]   cfgAddr,
  input  logic [V_W-1:0]   cfgData,
  input  logic [H_W-1:0]   hCount,
  input  logic [V_W-1:0]   vCount,
  output rasterStb_t       stb
);

  localparam int CTRL_ADDR = (1 << A_W) - 1;
  localparam int HALF_BIT  = H_W;

  // Horizontal and vertical compare banks
  for (genvar i = 0; i < N_CMP; i++) begin : g_reg
    localparam bit RST_ONES = (i == IDX_TOT) || (i == IDX_SYNC);
    logic [H_W-1:0] hr;
    logic [V_W-1:0] vr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hr <= RST_ONES ? {H_W{1'b1}} : {H_W{1'b0}};
      end else if (cfgWrEn && cfgAddr == A_W'(i)) begin
        hr <= cfgData[H_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vr <= RST_ONES ? {V_W{1'b1}} : {V_W{1'b0}};
      end else if (cfgWrEn && cfgAddr == A_W'(V_BASE + i)) begin
        vr <= cfgData;
      end
    end
  end

  logic              dispHalf;
  logic [MODE_W-1:0] modeReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dispHalf <= 1'b0;
    end else if (cfgWrEn && cfgAddr == A_W'(IDX_DBEG)) begin
      dispHalf <= cfgData[HALF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg <= '0;
    end else if (cfgWrEn && cfgAddr == A_W'(CTRL_ADDR)) begin
      modeReg <= cfgData[MODE_W-1:0];
    end
  end

  // Effective vertical period, extended in the slower frame-rate mode
  logic [V_W:0] vTotEff;
  assign vTotEff = {1'b0, g_reg[IDX_TOT].vr} + (V_W+1)'(modeReg[MB_F50] ? PAL_EXTRA : 0);

  always_comb begin
    stb          = '0;
    stb.hWrap    = hCount >= g_reg[IDX_TOT].hr;
    stb.vWrap    = {1'b0, vCount} >= vTotEff;
    stb.hSyncIn  = hCount >= g_reg[IDX_SYNC].hr;
    stb.vSyncIn  = vCount >= g_reg[IDX_SYNC].vr;
    stb.hDispIn  = (hCount >= g_reg[IDX_DBEG].hr) && (hCount < g_reg[IDX_DEND].hr);
    stb.vDispIn  = (vCount >= g_reg[IDX_DBEG].vr) && (vCount < g_reg[IDX_DEND].vr);
    stb.hBordIn  = (hCount >= g_reg[IDX_BBEG].hr) && (hCount < g_reg[IDX_BEND].hr);
    stb.vBordIn  = (vCount >= g_reg[IDX_BBEG].vr) && (vCount < g_reg[IDX_BEND].vr);
    stb.dispHalf = dispHalf;
    stb.hPol     = modeReg[MB_HPOL];
    stb.vPol     = modeReg[MB_VPOL];
    stb.ilace    = modeReg[MB_ILACE];
    stb.dblScan  = modeReg[MB_DBL];
  end

  // R9
  htot_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr == A_W'(IDX_TOT)) |=> (g_reg[IDX_TOT].hr == $past(cfgData[H_W-1:0])));

  // R9
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && (cfgAddr == A_W'(6) || cfgAddr == A_W'(7) || cfgAddr == A_W'(14)))
      |=> ($stable(modeReg) && $stable(dispHalf)));

endmodule

// File: rtl/rasterCount.sv
module rasterCount
  import raster_pkg::*;
#(
  parameter int H_W = 9,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pixEn,
  input  rasterStb_t     stb,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           hSync,
  output logic           vSync,
  output logic           dispEn,
  output logic           bordEn,
  output logic [V_W-1:0] lineIdx
);

  logic field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCount <= '0;
      vCount <= '0;
      field  <= 1'b0;
    end else if (pixEn) begin
      if (stb.hWrap) begin
        hCount <= '0;
        if (stb.vWrap) begin
          vCount <= '0;
          field  <= ~field;
        end else begin
          vCount <= vCount + 1'b1;
        end
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  logic hSyncAct;
  logic vSyncAct;
  logic dispAct;

  assign hSyncAct = stb.hSyncIn & vCount[0];
  assign vSyncAct = stb.vSyncIn;
  assign dispAct  = stb.hDispIn & stb.vDispIn & (vCount[0] == stb.dispHalf);

  assign hSync  = ~(hSyncAct ^ stb.hPol);
  assign vSync  = ~(vSyncAct ^ stb.vPol);
  assign dispEn = dispAct;
  assign bordEn = stb.hBordIn & stb.vBordIn & ~dispAct;

  always_comb begin
    if (stb.dblScan) begin
      lineIdx = {2'b00, vCount[V_W-1:2]};
    end else if (stb.ilace) begin
      lineIdx = {vCount[V_W-1:1], field};
    end else begin
      lineIdx = {1'b0, vCount[V_W-1:1]};
    end
  end

  // R2
  hcount_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pixEn |=> ($stable(hCount) && $stable(vCount)));

  // R2
  hcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixEn && !stb.hWrap) |=> (hCount == $past(hCount) + 1'b1));

  // R3
  vcount_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pixEn && stb.hWrap) |=> $stable(vCount));

  // R8
  field_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pixEn && stb.hWrap && stb.vWrap) |=> $stable(field));

endmodule

// File: rtl/rasterTimingGen.sv
module rasterTimingGen
  import raster_pkg::*;
#(
  parameter int H_W       = 9,
  parameter int V_W       = 11,
  parameter int A_W       = 4,
  parameter int PAL_EXTRA = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pixEn,
  input  logic           cfgWrEn,
  input  logic [A_W-1:0] cfgAddr,
  input  logic [V_W-1:0] cfgData,
  output logic           hSync,
  output logic           vSync,
  output logic           dispEn,
  output logic           bordEn,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic [V_W-1:0] lineIdx
);

  rasterStb_t stb;

  rasterCtrl #(
    .H_W(H_W), .V_W(V_W), .A_W(A_W), .PAL_EXTRA(PAL_EXTRA)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hCount(hCount), .vCount(vCount),
    .stb(stb)
  );

  rasterCount #(
    .H_W(H_W), .V_W(V_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .stb(stb),
    .hCount(hCount), .vCount(vCount),
    .hSync(hSync), .vSync(vSync),
    .dispEn(dispEn), .bordEn(bordEn),
    .lineIdx(lineIdx)
  );

endmodule

// File: tb/rasterTimingGen_bench.sv
module rasterTimingGen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PAL_X      = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pixEn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [10:0] cfgData = '0;
  logic        hSync, vSync, dispEn, bordEn;
  logic [8:0]  hCount;
  logic [10:0] vCount, lineIdx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model state
  int mh = 0, mv = 0, mfield = 0;
  int hr[6];
  int vr[6];
  int mhalf = 0, mmode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rasterTimingGen u_rasterTimingGen (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn), .bordEn(bordEn),
    .hCount(hCount), .vCount(vCount), .lineIdx(lineIdx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d mode=%0d)",
               tag, act, exp, mh, mv, mmode);
    end
  endtask

  task automatic checkAll();
    int hAct, vAct, dE, hWin, vWin, hbWin, vbWin, li;
    hAct  = (mh >= hr[5]) && (mv % 2 == 1);
    vAct  = (mv >= vr[5]);
    hWin  = (mh >= hr[3]) && (mh < hr[4]);
    vWin  = (mv >= vr[3]) && (mv < vr[4]);
    dE    = hWin && vWin && ((mv % 2) == mhalf);
    hbWin = (mh >= hr[1]) && (mh < hr[2]);
    vbWin = (mv >= vr[1]) && (mv < vr[2]);
    if (mmode[3])      li = mv >> 2;
    else if (mmode[2]) li = ((mv >> 1) << 1) | mfield;
    else               li = mv >> 1;
    chk("R2 hCount", int'(hCount), mh);
    chk("R3 vCount", int'(vCount), mv);
    chk("R4 hSync", int'(hSync), mmode[0] ? hAct : int'(!hAct));
    chk("R5 vSync", int'(vSync), mmode[1] ? vAct : int'(!vAct));
    chk("R6 dispEn", int'(dispEn), dE);
    chk("R7 bordEn", int'(bordEn), (hbWin && vbWin && !dE) ? 1 : 0);
    chk("R8 lineIdx", int'(lineIdx), li);
  endtask

  task automatic step(input bit pe, input bit we, input int a, input int d);
    int vTot;
    @(negedge clk);
    pixEn   = pe;
    cfgWrEn = we;
    cfgAddr = 4'(a);
    cfgData = 11'(d);
    @(posedge clk);
    #1;
    if (pe) begin
      if (mh >= hr[0]) begin
        mh = 0;
        vTot = vr[0] + (mmode[4] ? PAL_X : 0);
        if (mv >= vTot) begin
          mv = 0;
          mfield = mfield ^ 1;
        end else begin
          mv++;
        end
      end else begin
        mh++;
      end
    end
    if (we) begin
      if (a < 6)                 hr[a] = d & 9'h1FF;
      else if (a >= 8 && a < 14) vr[a-8] = d;
      else if (a == 15)          mmode = d & 5'h1F;
      if (a == 3) mhalf = (d >> 9) & 1;
    end
    cfgWrEn = 1'b0;
    checkAll();
  endtask

  task automatic wr(input int a, input int d);
    step(1'b1, 1'b1, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    hr = '{511, 0, 0, 0, 0, 511};
    vr = '{2047, 0, 0, 0, 0, 2047};
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    chk("R1 hCount", int'(hCount), 0);
    chk("R1 vCount", int'(vCount), 0);
    chk("R1 hSync", int'(hSync), 1);
    chk("R1 vSync", int'(vSync), 1);
    chk("R1 dispEn", int'(dispEn), 0);
    chk("R1 bordEn", int'(bordEn), 0);
    chk("R1 lineIdx", int'(lineIdx), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 0, 0);

    // R9 program a small raster
    wr(0, 9);  wr(1, 1);  wr(2, 9);  wr(3, 3);  wr(4, 7);  wr(5, 8);
    wr(8, 11); wr(9, 1);  wr(10, 10); wr(11, 2); wr(12, 8); wr(13, 10);

    // Sweep every mode value; odd values flip half select and gap pixEn
    for (int m = 0; m < 32; m++) begin
      wr(15, m);
      wr(3, (m % 2 == 1) ? ((1 << 9) | 3) : 3);
      for (int k = 0; k < 330; k++) step((m % 2 == 0) || (k % 3 != 2), 1'b0, 0, 0);
    end

    // R9 unmapped addresses leave everything unchanged
    wr(15, 5'b00101);
    wr(6, 11'h7FF); wr(7, 11'h7FF); wr(14, 11'h7FF);
    for (int k = 0; k < 120; k++) step(1'b1, 1'b0, 0, 0);

    // R9 lowering the period below the current count wraps at once
    while (mh != 8) step(1'b1, 1'b0, 0, 0);
    wr(0, 4);
    for (int k = 0; k < 150; k++) step(1'b1, 1'b0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule